// File: doc/BRIEF.md
# Scan-Line Address Generator with Three-Window Overlay

This block walks the panel scan one line at a time and, for every line, works out which line of display RAM feeds the base picture and whether one of three overlay windows covers that line. A frame-start pulse rewinds the scan to the first panel line, and every line strobe produces the addresses for the current line and then moves on to the next. The register values come in as plain inputs: the number of driven lines, the scan start, the base RAM area, one RAM area and one panel position for each overlay window, a vertical magnification, a base-picture enable and the field mode.

Each overlay window repeats every RAM line it holds n times on the panel, where n is the magnification. The overlay RAM address therefore steps once every n panel lines. A small sub-line counter inside each window produces this step, so no divider is needed. The block also reports how the pixel stage should combine the two pictures. It does not blend when no overlay is present. It mixes the overlay with the base picture when the base picture is shown, and it shows the overlay fully opaque when the base picture is switched off. In interlaced drive the overlay is removed entirely.

A registered configuration error flag reports register settings that break the screen, base area, window order or RAM separation rules. Pixel arithmetic and the RAM itself are outside this block.

Top module: `ovl_line_addr_gen`

## Requirements
- R1: All line outputs are registered and change only in the clock after a line strobe or frame-start pulse. A frame-start pulse sets the line index to 0 and drives line_valid low in the following clock, and it takes priority over a line strobe in the same cycle. The first strobe after it reports line 0.
- R2: For line index k, base_addr equals base_start + k (modulo the address width), and line_valid is 1 exactly when k < line_count.
- R3: Window x (x = 0, 1, 2) covers the panel lines from osd_pos[x] up to, but not including, osd_pos[x] + n*(osd_end[x] - osd_start[x] + 1). On such a line osd_hit is 1 and osd_idx is x. If two windows cover the same line, the lower index wins.
- R4: On a covered line, osd_addr equals osd_start[x] + floor((k - osd_pos[x]) / n).
- R5: The effective magnification n is 1 when mag is 0, is 4 when mag is above 4, and is otherwise equal to mag.
- R6: blend_mode is 2'b00 when osd_hit is 0, 2'b01 (mix) when osd_hit is 1 and base_en is 1, and 2'b10 (overlay fully opaque) when osd_hit is 1 and base_en is 0.
- R7: When field_mode is 2'b11 (interlaced), osd_hit is 0 and blend_mode is 2'b00 on every line, while base_addr and line_valid keep their normal values.
- R8: cfg_err is set, one clock after the settings apply, when line_count > 320, when scan_start + line_count > 320, or when scan_start differs from base_start.
- R9: cfg_err is set when base_end < base_start or when base_end - base_start < line_count.
- R10: cfg_err is set when any overlay window has osd_end < osd_start, when the RAM area of any overlay window overlaps another overlay area or the base area, when the panel span of window x ends after osd_pos[x+1], or when the span of window 2 ends after line_count.
- R11: osd_hit is 0 on every line whose index is not below line_count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | Rewinds the scan to line 0 |
| line_strobe | input | 1 | Produces outputs for the current line, then advances |
| line_count | input | 9 | Number of driven panel lines |
| scan_start | input | 9 | First gate line of the scan |
| base_start | input | 9 | First base-picture RAM line |
| base_end | input | 9 | Last base-picture RAM line |
| osd_start | input | 3x9 | First RAM line of each overlay window |
| osd_end | input | 3x9 | Last RAM line of each overlay window |
| osd_pos | input | 3x9 | First panel line of each overlay window |
| mag | input | 3 | Vertical magnification of the overlays |
| base_en | input | 1 | Base picture shown |
| field_mode | input | 2 | Drive mode; 2'b11 selects interlaced drive |
| line_valid | output | 1 | Current line lies within the driven lines |
| base_addr | output | 9 | Base-picture RAM line address |
| osd_hit | output | 1 | An overlay window covers the line |
| osd_idx | output | 2 | Index of the covering window |
| osd_addr | output | 9 | Overlay RAM line address |
| blend_mode | output | 2 | Combine mode: none, mix or opaque |
| cfg_err | output | 1 | Register settings break a rule |

## Verification
Assertions check every cycle that a hit never appears outside the driven lines, that interlaced drive never produces a hit, that a disabled base picture never yields the mix mode, that the blend mode agrees with the hit flag, and that line outputs stay put between strobes. The cases that only the bench scenarios can show are these: the overlay address really steps once every n lines across all magnifications, including the clamped values 0 and above 4; window boundaries fall on the right lines; and each class of bad register setting raises the error flag.

// File: rtl/ovl_pkg.sv
package ovl_pkg;

    localparam int ADDR_W    = 9;
    localparam int LINE_W    = 9;
    localparam int NUM_OSD   = 3;
    localparam int MAG_W     = 3;
    localparam int MAG_MAX   = 4;
    localparam int MAX_LINES = 320;

    localparam logic [1:0] FIELD_INTERLACE = 2'b11;

    typedef enum logic [1:0] {
        BLEND_NONE   = 2'b00,
        BLEND_ALPHA  = 2'b01,
        BLEND_OPAQUE = 2'b10
    } blend_e;

    // Clamp raw magnification into 1..top.
    function automatic int unsigned eff_mag(input int unsigned raw, input int unsigned top);
        if (raw == 0)
            return 1;
        else if (raw > top)
            return top;
        else
            return raw;
    endfunction

    // Two closed ranges share at least one value.
    function automatic bit ranges_meet(input int unsigned a_lo, input int unsigned a_hi,
                                       input int unsigned b_lo, input int unsigned b_hi);
        return (a_lo <= b_hi) && (b_lo <= a_hi);
    endfunction

endpackage

// File: rtl/ovl_line_seq.sv
module ovl_line_seq #(
    parameter int LINE_W = ovl_pkg::LINE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  logic              step,
    output logic [LINE_W-1:0] idx
);
    localparam logic [LINE_W-1:0] IDX_TOP = '1;

    always_ff @(posedge clk) begin
        if (rst || restart)
            idx <= '0;
        else if (step && idx != IDX_TOP)
            idx <= idx + 1'b1;
    end

    // R1: a frame start rewinds the scan
    a_r1_restart_zero: assert property (@(posedge clk) disable iff (rst)
        restart |=> idx == '0);

    // R2: each strobe moves one line on (saturating)
    a_r2_idx_advances: assert property (@(posedge clk) disable iff (rst)
        (step && !restart && idx != IDX_TOP) |=> idx == $past(idx) + 1'b1);

endmodule

// File: rtl/ovl_window.sv
module ovl_window #(
    parameter int ADDR_W = ovl_pkg::ADDR_W,
    parameter int LINE_W = ovl_pkg::LINE_W,
    parameter int MAG_W  = ovl_pkg::MAG_W,
    parameter int EXT_W  = ADDR_W + LINE_W + MAG_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  logic              step,
    input  logic [LINE_W-1:0] idx,
    input  logic [ADDR_W-1:0] ram_start,
    input  logic [ADDR_W-1:0] ram_end,
    input  logic [LINE_W-1:0] pos,
    input  logic [MAG_W-1:0]  mag_eff,
    output logic              in_win,
    output logic [EXT_W-1:0]  span_end,
    output logic [ADDR_W-1:0] cur_addr
);
    logic [EXT_W-1:0]  ram_lines;
    logic [MAG_W-1:0]  sub;
    logic [ADDR_W-1:0] off;

    always_comb begin
        ram_lines = EXT_W'(ram_end) - EXT_W'(ram_start) + EXT_W'(1);
        span_end  = EXT_W'(pos) + ram_lines * EXT_W'(mag_eff);
        in_win    = (EXT_W'(idx) >= EXT_W'(pos)) && (EXT_W'(idx) < span_end);
        cur_addr  = ram_start + off;
    end

    // Sub-line counter: the RAM offset moves once per mag_eff panel lines.
    always_ff @(posedge clk) begin
        if (rst || restart) begin
            sub <= '0;
            off <= '0;
        end else if (step && in_win) begin
            if (sub >= mag_eff - MAG_W'(1)) begin
                sub <= '0;
                off <= off + 1'b1;
            end else begin
                sub <= sub + 1'b1;
            end
        end
    end

    // R4: the RAM offset never moves outside a covered line
    a_r4_offset_holds_outside: assert property (@(posedge clk) disable iff (rst)
        (!in_win && !restart) |=> $stable(off));

    // R4: entering a frame starts the window at its first RAM line
    a_r4_restart_offset: assert property (@(posedge clk) disable iff (rst)
        restart |=> (off == '0 && sub == '0));

endmodule

// File: rtl/ovl_cfg_check.sv
module ovl_cfg_check #(
    parameter int ADDR_W    = ovl_pkg::ADDR_W,
    parameter int LINE_W    = ovl_pkg::LINE_W,
    parameter int NUM_OSD   = ovl_pkg::NUM_OSD,
    parameter int MAX_LINES = ovl_pkg::MAX_LINES,
    parameter int EXT_W     = 16
) (
    input  logic [LINE_W-1:0]               line_count,
    input  logic [LINE_W-1:0]               scan_start,
    input  logic [ADDR_W-1:0]               base_start,
    input  logic [ADDR_W-1:0]               base_end,
    input  logic [NUM_OSD-1:0][ADDR_W-1:0]  osd_start,
    input  logic [NUM_OSD-1:0][ADDR_W-1:0]  osd_end,
    input  logic [NUM_OSD-1:0][LINE_W-1:0]  osd_pos,
    input  logic [NUM_OSD-1:0][EXT_W-1:0]   span_end,
    output logic                            err
);
    import ovl_pkg::*;

    logic screen_bad, base_bad, ram_bad, order_bad;

    always_comb begin
        int unsigned nl, scn, bsa, bea;
        nl  = 32'(line_count);
        scn = 32'(scan_start);
        bsa = 32'(base_start);
        bea = 32'(base_end);

        screen_bad = (nl > MAX_LINES) || (scn + nl > MAX_LINES) || (scn != bsa);
        base_bad   = (bea < bsa) || ((bea - bsa) < nl);

        ram_bad   = 1'b0;
        order_bad = 1'b0;
        for (int i = 0; i < NUM_OSD; i++) begin
            if (osd_end[i] < osd_start[i])
                ram_bad = 1'b1;
            if (ranges_meet(32'(osd_start[i]), 32'(osd_end[i]), bsa, bea))
                ram_bad = 1'b1;
            for (int j = i + 1; j < NUM_OSD; j++) begin
                if (ranges_meet(32'(osd_start[i]), 32'(osd_end[i]),
                                32'(osd_start[j]), 32'(osd_end[j])))
                    ram_bad = 1'b1;
            end
            if (i < NUM_OSD - 1) begin
                if (32'(span_end[i]) > 32'(osd_pos[(i + 1) % NUM_OSD]))
                    order_bad = 1'b1;
            end else begin
                if (32'(span_end[i]) > nl)
                    order_bad = 1'b1;
            end
        end

        err = screen_bad || base_bad || ram_bad || order_bad;
    end

endmodule

// File: rtl/ovl_line_addr_gen.sv
module ovl_line_addr_gen #(
    parameter int ADDR_W    = ovl_pkg::ADDR_W,
    parameter int LINE_W    = ovl_pkg::LINE_W,
    parameter int NUM_OSD   = ovl_pkg::NUM_OSD,
    parameter int MAG_W     = ovl_pkg::MAG_W,
    parameter int MAG_MAX   = ovl_pkg::MAG_MAX,
    parameter int MAX_LINES = ovl_pkg::MAX_LINES,
    localparam int IDX_W    = (NUM_OSD > 1) ? $clog2(NUM_OSD) : 1,
    localparam int EXT_W    = ADDR_W + LINE_W + MAG_W
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            frame_start,
    input  logic                            line_strobe,
    input  logic [LINE_W-1:0]               line_count,
    input  logic [LINE_W-1:0]               scan_start,
    input  logic [ADDR_W-1:0]               base_start,
    input  logic [ADDR_W-1:0]               base_end,
    input  logic [NUM_OSD-1:0][ADDR_W-1:0]  osd_start,
    input  logic [NUM_OSD-1:0][ADDR_W-1:0]  osd_end,
    input  logic [NUM_OSD-1:0][LINE_W-1:0]  osd_pos,
    input  logic [MAG_W-1:0]                mag,
    input  logic                            base_en,
    input  logic [1:0]                      field_mode,
    output logic                            line_valid,
    output logic [ADDR_W-1:0]               base_addr,
    output logic                            osd_hit,
    output logic [IDX_W-1:0]                osd_idx,
    output logic [ADDR_W-1:0]               osd_addr,
    output logic [1:0]                      blend_mode,
    output logic                            cfg_err
);
    import ovl_pkg::*;

    logic                           step;
    logic [LINE_W-1:0]              idx;
    logic [MAG_W-1:0]               mag_eff;
    logic [NUM_OSD-1:0]             win_hit;
    logic [NUM_OSD-1:0][EXT_W-1:0]  win_end;
    logic [NUM_OSD-1:0][ADDR_W-1:0] win_addr;
    logic                           sel_hit;
    logic [IDX_W-1:0]               sel_idx;
    logic [ADDR_W-1:0]              sel_addr;
    logic                           in_range;
    logic                           osd_ok;
    blend_e                         blend_next;
    logic                           err_next;

    assign step    = line_strobe && !frame_start;
    assign mag_eff = MAG_W'(eff_mag(32'(mag), MAG_MAX));

    ovl_line_seq #(.LINE_W(LINE_W)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .restart (frame_start),
        .step    (step),
        .idx     (idx)
    );

    for (genvar x = 0; x < NUM_OSD; x++) begin : g_win
        ovl_window #(
            .ADDR_W (ADDR_W),
            .LINE_W (LINE_W),
            .MAG_W  (MAG_W),
            .EXT_W  (EXT_W)
        ) u_win (
            .clk       (clk),
            .rst       (rst),
            .restart   (frame_start),
            .step      (step),
            .idx       (idx),
            .ram_start (osd_start[x]),
            .ram_end   (osd_end[x]),
            .pos       (osd_pos[x]),
            .mag_eff   (mag_eff),
            .in_win    (win_hit[x]),
            .span_end  (win_end[x]),
            .cur_addr  (win_addr[x])
        );
    end

    ovl_cfg_check #(
        .ADDR_W    (ADDR_W),
        .LINE_W    (LINE_W),
        .NUM_OSD   (NUM_OSD),
        .MAX_LINES (MAX_LINES),
        .EXT_W     (EXT_W)
    ) u_cfg (
        .line_count (line_count),
        .scan_start (scan_start),
        .base_start (base_start),
        .base_end   (base_end),
        .osd_start  (osd_start),
        .osd_end    (osd_end),
        .osd_pos    (osd_pos),
        .span_end   (win_end),
        .err        (err_next)
    );

    // Lowest-numbered covering window wins.
    always_comb begin
        sel_hit  = 1'b0;
        sel_idx  = '0;
        sel_addr = '0;
        for (int x = NUM_OSD - 1; x >= 0; x--) begin
            if (win_hit[x]) begin
                sel_hit  = 1'b1;
                sel_idx  = IDX_W'(x);
                sel_addr = win_addr[x];
            end
        end
        in_range = EXT_W'(idx) < EXT_W'(line_count);
        osd_ok   = in_range && sel_hit && (field_mode != FIELD_INTERLACE);
        if (!osd_ok)
            blend_next = BLEND_NONE;
        else if (base_en)
            blend_next = BLEND_ALPHA;
        else
            blend_next = BLEND_OPAQUE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            line_valid <= 1'b0;
            base_addr  <= '0;
            osd_hit    <= 1'b0;
            osd_idx    <= '0;
            osd_addr   <= '0;
            blend_mode <= BLEND_NONE;
            cfg_err    <= 1'b0;
        end else begin
            cfg_err <= err_next;
            if (frame_start) begin
                line_valid <= 1'b0;
                osd_hit    <= 1'b0;
                osd_idx    <= '0;
                osd_addr   <= '0;
                blend_mode <= BLEND_NONE;
            end else if (line_strobe) begin
                line_valid <= in_range;
                base_addr  <= base_start + ADDR_W'(idx);
                osd_hit    <= osd_ok;
                osd_idx    <= osd_ok ? sel_idx : '0;
                osd_addr   <= osd_ok ? sel_addr : '0;
                blend_mode <= blend_next;
            end
        end
    end

    // R11: no overlay outside the driven lines
    a_r11_hit_needs_valid: assert property (@(posedge clk) disable iff (rst)
        osd_hit |-> line_valid);

    // R7: interlaced drive removes the overlay
    a_r7_interlace_no_osd: assert property (@(posedge clk) disable iff (rst)
        (step && field_mode == FIELD_INTERLACE) |=> (!osd_hit && blend_mode == BLEND_NONE));

    // R6: base picture off never asks for a mix
    a_r6_opaque_when_base_off: assert property (@(posedge clk) disable iff (rst)
        (step && !base_en) |=> blend_mode != BLEND_ALPHA);

    // R6: blend mode follows the hit flag
    a_r6_blend_tracks_hit: assert property (@(posedge clk) disable iff (rst)
        osd_hit == (blend_mode != BLEND_NONE));

    // R1: frame start invalidates the line outputs
    a_r1_restart_invalid: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> !line_valid);

    // R1: outputs hold between strobes
    a_r1_hold_between_lines: assert property (@(posedge clk) disable iff (rst)
        (!line_strobe && !frame_start) |=>
            ($stable(base_addr) && $stable(line_valid) && $stable(osd_hit) && $stable(osd_addr)));

    // R2: base address is the start plus the line index
    a_r2_base_addr: assert property (@(posedge clk) disable iff (rst)
        step |=> base_addr == ADDR_W'($past(base_start) + ADDR_W'($past(idx))));

endmodule

// File: tb/ovl_line_addr_gen_bench.sv
`timescale 1ns/1ps
module ovl_line_addr_gen_bench;
    import ovl_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic frame_start = 1'b0;
    logic line_strobe = 1'b0;
    logic [8:0] line_count = '0, scan_start = '0, base_start = '0, base_end = '0;
    logic [2:0][8:0] osd_start = '0, osd_end = '0, osd_pos = '0;
    logic [2:0] mag = '0;
    logic base_en = 1'b0;
    logic [1:0] field_mode = '0;
    logic line_valid, osd_hit, cfg_err;
    logic [8:0] base_addr, osd_addr;
    logic [1:0] osd_idx, blend_mode;

    always #2.5 clk = ~clk;

    ovl_line_addr_gen u_ovl_line_addr_gen (
        .clk(clk), .rst(rst), .frame_start(frame_start), .line_strobe(line_strobe),
        .line_count(line_count), .scan_start(scan_start), .base_start(base_start),
        .base_end(base_end), .osd_start(osd_start), .osd_end(osd_end), .osd_pos(osd_pos),
        .mag(mag), .base_en(base_en), .field_mode(field_mode),
        .line_valid(line_valid), .base_addr(base_addr), .osd_hit(osd_hit),
        .osd_idx(osd_idx), .osd_addr(osd_addr), .blend_mode(blend_mode), .cfg_err(cfg_err)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    int nl, bsa, bea, magr, be, fm;
    int osa[3], oea[3], odp[3];

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int ref_mag(input int raw);
        if (raw == 0) return 1;
        if (raw > 4) return 4;
        return raw;
    endfunction

    task automatic apply();
        @(negedge clk);
        line_count = 9'(nl); scan_start = 9'(bsa); base_start = 9'(bsa); base_end = 9'(bea);
        for (int x = 0; x < 3; x++) begin
            osd_start[x] = 9'(osa[x]); osd_end[x] = 9'(oea[x]); osd_pos[x] = 9'(odp[x]);
        end
        mag = 3'(magr); base_en = 1'(be); field_mode = 2'(fm);
    endtask

    task automatic make_valid();
        int n, p, r;
        int lens[3];
        magr = $urandom_range(0, 7);
        n = ref_mag(magr);
        p = $urandom_range(0, 3);
        for (int x = 0; x < 3; x++) begin
            lens[x] = $urandom_range(1, 4);
            odp[x] = p;
            p = p + n * lens[x] + $urandom_range(0, 3);
        end
        nl  = p + $urandom_range(0, 5);
        bsa = $urandom_range(0, 320 - nl);
        bea = bsa + nl + $urandom_range(0, 3);
        r = bea + 1;
        for (int x = 0; x < 3; x++) begin
            osa[x] = r + $urandom_range(0, 2);
            oea[x] = osa[x] + lens[x] - 1;
            r = oea[x] + 1;
        end
        be = $urandom_range(0, 1);
        fm = $urandom_range(0, 3);
    endtask

    task automatic check_line(input int k);
        int n, ehit, eidx, eaddr, eblend;
        bit ev;
        string htag, atag;
        n = ref_mag(magr);
        ev = (k < nl);
        ehit = 0; eidx = 0; eaddr = 0;
        for (int x = 0; x < 3; x++) begin
            int span;
            span = n * (oea[x] - osa[x] + 1);
            if (ehit == 0 && k >= odp[x] && k < odp[x] + span) begin
                ehit = 1; eidx = x; eaddr = osa[x] + (k - odp[x]) / n;
            end
        end
        if (!ev || fm == 3) ehit = 0;
        eblend = (ehit == 0) ? 0 : (be != 0 ? 1 : 2);
        htag = (fm == 3) ? "R7" : (!ev ? "R11" : "R3");
        atag = (magr == 0 || magr > 4) ? "R5" : "R4";
        chk(line_valid == ev, "R2", "line_valid", int'(line_valid), int'(ev));
        if (ev) chk(base_addr == 9'(bsa + k), "R2", "base_addr", int'(base_addr), (bsa + k) % 512);
        chk(int'(osd_hit) == ehit, htag, "osd_hit", int'(osd_hit), ehit);
        if (ehit != 0) begin
            chk(int'(osd_idx) == eidx, "R3", "osd_idx", int'(osd_idx), eidx);
            chk(int'(osd_addr) == eaddr, atag, "osd_addr", int'(osd_addr), eaddr);
        end
        chk(int'(blend_mode) == eblend, "R6", "blend_mode", int'(blend_mode), eblend);
    endtask

    task automatic strobe_once();
        line_strobe = 1'b1;
        @(negedge clk);
        line_strobe = 1'b0;
    endtask

    task automatic run_frame();
        @(negedge clk);
        chk(cfg_err == 1'b0, "R8", "cfg_err on valid settings", int'(cfg_err), 0);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        chk(line_valid == 1'b0, "R1", "line_valid after frame start", int'(line_valid), 0);
        for (int k = 0; k < nl + 2; k++) begin
            strobe_once();
            check_line(k);
            repeat ($urandom_range(0, 2)) @(negedge clk);
        end
    endtask

    task automatic expect_err(input string req, input string what);
        apply();
        repeat (2) @(negedge clk);
        chk(cfg_err == 1'b1, req, what, int'(cfg_err), 1);
    endtask

    initial begin
        void'($urandom(32'h0C0FFEE5));
        repeat (3) @(negedge clk);
        chk(line_valid == 1'b0, "R1", "reset line_valid", int'(line_valid), 0);
        chk(osd_hit == 1'b0, "R1", "reset osd_hit", int'(osd_hit), 0);
        chk(blend_mode == 2'b00, "R1", "reset blend_mode", int'(blend_mode), 0);
        rst = 1'b0;

        // Directed: mag 0, base on, progressive; then mag 7, base off.
        make_valid(); magr = 0; fm = 0; be = 1; apply(); run_frame();
        make_valid(); magr = 7; fm = 1; be = 0; apply(); run_frame();
        make_valid(); fm = 3; apply(); run_frame();

        for (int f = 0; f < 25; f++) begin
            make_valid();
            apply();
            run_frame();
        end

        // R1: frame start beats a strobe in the same cycle; then line 0 again.
        make_valid(); fm = 0; apply();
        @(negedge clk); frame_start = 1'b1; @(negedge clk); frame_start = 1'b0;
        repeat (3) strobe_once();
        frame_start = 1'b1; line_strobe = 1'b1;
        @(negedge clk);
        frame_start = 1'b0; line_strobe = 1'b0;
        chk(line_valid == 1'b0, "R1", "strobe with frame start", int'(line_valid), 0);
        strobe_once();
        chk(base_addr == 9'(bsa), "R1", "first line after restart", int'(base_addr), bsa);
        repeat (3) @(negedge clk);
        chk(base_addr == 9'(bsa), "R1", "hold without strobe", int'(base_addr), bsa);
        chk(line_valid == 1'b1, "R1", "valid hold without strobe", int'(line_valid), 1);

        // Configuration errors, each from a fresh valid setting.
        make_valid(); nl = 321; bsa = 0; expect_err("R8", "line_count above 320");
        make_valid(); apply(); scan_start = 9'(bsa + 1);
        repeat (2) @(negedge clk);
        chk(cfg_err == 1'b1, "R8", "scan start differs from base start", int'(cfg_err), 1);
        make_valid(); bea = bsa + nl - 1; expect_err("R9", "base area too short");
        make_valid(); odp[1] = odp[0]; expect_err("R10", "windows out of order");
        make_valid(); osa[1] = osa[0]; expect_err("R10", "overlay RAM overlap");
        make_valid(); nl = odp[2]; bea = bsa + nl; expect_err("R10", "window 2 past line_count");
        make_valid(); osa[0] = bsa; expect_err("R10", "overlay RAM inside base area");
        make_valid(); apply(); repeat (2) @(negedge clk);
        chk(cfg_err == 1'b0, "R9", "error clears on valid settings", int'(cfg_err), 0);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule